// File: doc/BRIEF.md
# Reset Hold Duration Counter

This block measures how long an active-low hold line (typically a reset push-button) is kept asserted. The line is brought into the clock domain by a two-stage synchronizer. While the synchronized line is low, a saturating counter advances once per reference-clock cycle. After the line is released, the counter keeps its value so firmware can read it later. A small register port lets firmware read the count, clear it, and program a threshold. The `long_press_o` output rises whenever the count reaches the threshold. Firmware can use it, for example, to start a factory-restore action after a button has been held for several seconds. With a 25 MHz reference, one second of hold time equals 25,000,000 counts.

The control is a four-state machine:
- `ST_IDLE`: the count is zero and the line is high.
- `ST_RUN`: the line is low and the counter is advancing.
- `ST_SAT`: the line is low and the counter is pinned at its maximum.
- `ST_HOLD`: the line is high and a non-zero count is held.

Transitions:
- `ST_IDLE` goes to `ST_RUN` when the line is pressed.
- `ST_RUN` goes to `ST_SAT` when the count reaches its maximum.
- `ST_RUN` and `ST_SAT` go to `ST_HOLD` on release.
- `ST_HOLD` goes back to `ST_RUN` on a new press.
- A clear moves every state to `ST_RUN` if the line is low, or to `ST_IDLE` if it is high.

Top module: `reset_hold_counter`

## Requirements
- R1: While the synchronized hold line is low and no clear is written, the count increases by exactly one per clock cycle.
- R2: The hold line passes through a two-flop synchronizer. A low level present at N consecutive rising edges yields a count of exactly N once the release has propagated.
- R3: The count saturates at 2^CNT_W-1 (29 bits by default) and never wraps while the line stays low.
- R4: A write to address 0 with bit 31 set clears the count to zero at that clock edge. A write to address 0 with bit 31 clear leaves the count unchanged.
- R5: While the line is high and no clear is written, the count holds its value.
- R6: A clear written while the line is still low restarts the count from zero, and counting resumes on the following cycles.
- R7: Reading address 0 returns the count in bits CNT_W-1:0. All higher bits, including bit 31, read as zero.
- R8: Writing address 1 loads the threshold from bits CNT_W-1:0 of the write data, and reading address 1 returns it zero-extended. `long_press_o` is high exactly when count >= threshold.
- R9: After reset the count is 0, the threshold is all ones (2^CNT_W-1), and `long_press_o` is low.
- R10: A second press without an intervening clear continues counting from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| hold_n_i | input | 1 | Asynchronous active-low hold line being timed |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 = count/clear, 1 = threshold |
| wr_data_i | input | 32 | Write data; bit 31 at address 0 is the clear bit |
| rd_addr_i | input | 1 | Read address: 0 = count, 1 = threshold |
| rd_data_o | output | 32 | Combinational read data |
| long_press_o | output | 1 | High while count >= threshold |

## Verification
The assertions take `hold_n_i` as fully asynchronous. They rely only on the synchronized copy, so they make no assumption about its setup timing. They do assume the write strobe and address are sampled as clean synchronous signals. The stimulus drives every input on the falling clock edge and keeps the hold line high throughout reset, so the synchronizer starts from a released state. Saturation is reached within the run by building the bench with a narrower counter width.

// File: rtl/rhd_pkg.sv
package rhd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SAT  = 2'd2,
        ST_HOLD = 2'd3
    } rhd_state_e;

    localparam logic ADDR_COUNT = 1'b0;
    localparam logic ADDR_THR   = 1'b1;

endpackage

// File: rtl/rhd_sync.sv
module rhd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rhd_fsm.sv
module rhd_fsm
    import rhd_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_low_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output rhd_state_e       state_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - 1'b1;

    rhd_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = line_low_i ? ST_RUN : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (line_low_i) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (!line_low_i)            state_d = ST_HOLD;
                    else if (count_q == CNT_NEAR ||
                             count_q == CNT_MAX) state_d = ST_SAT;
                end
                ST_SAT: begin
                    if (!line_low_i) state_d = ST_HOLD;
                end
                ST_HOLD: begin
                    if (line_low_i) begin
                        state_d = (count_q == CNT_NEAR || count_q == CNT_MAX)
                                  ? ST_SAT : ST_RUN;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // counter datapath, steered by the same inputs
    always_comb begin
        count_d = count_q;
        if (clr_i) begin
            count_d = '0;
        end else if (line_low_i && (count_q != CNT_MAX)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;
    assign state_o = state_q;

    // R1: one step per cycle while the line is low
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_low_i && !clr_i && count_q != CNT_MAX) |=> (count_q == $past(count_q) + 1'b1));

    // R3: pinned at maximum
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && !clr_i) |=> (count_q == CNT_MAX));

    // R4: clear takes effect at the edge
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_q == '0));

    // R5: held while released
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_low_i && !clr_i) |=> $stable(count_q));

    // R9: idle state always carries a zero count
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (count_q == '0));

    // R3: saturated state only at maximum
    p_sat_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAT) |-> (count_q == CNT_MAX));
endmodule

// File: rtl/rhd_regs.sv
module rhd_regs
    import rhd_pkg::*;
#(
    parameter int CNT_W   = 29,
    parameter int DATA_W  = 32,
    parameter int CLR_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_addr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              clr_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              long_press_o
);
    localparam int PAD_W = DATA_W - CNT_W;

    logic [CNT_W-1:0] thr_q;

    assign clr_o = wr_en_i && (wr_addr_i == ADDR_COUNT) && wr_data_i[CLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '1;
        end else if (wr_en_i && (wr_addr_i == ADDR_THR)) begin
            thr_q <= wr_data_i[CNT_W-1:0];
        end
    end

    always_comb begin
        unique case (rd_addr_i)
            ADDR_COUNT: rd_data_o = {{PAD_W{1'b0}}, count_i};
            ADDR_THR:   rd_data_o = {{PAD_W{1'b0}}, thr_q};
            default:    rd_data_o = '0;
        endcase
    end

    assign long_press_o = (count_i >= thr_q);

    // R7: padding bits, including the clear bit, never read as one
    p_rd_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DATA_W-1:CNT_W] == '0);

    // R8: threshold captured from the write data
    p_thr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_THR) |=> (thr_q == $past(wr_data_i[CNT_W-1:0])));
endmodule

// File: rtl/reset_hold_counter.sv
module reset_hold_counter
    import rhd_pkg::*;
#(
    parameter int CNT_W   = 29,
    parameter int DATA_W  = 32,
    parameter int CLR_BIT = 31,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_n_i,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              long_press_o
);
    logic             hold_n_sync;
    logic             clr;
    logic [CNT_W-1:0] count;
    rhd_state_e       state;

    rhd_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (hold_n_i),
        .sync_o  (hold_n_sync)
    );

    rhd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_low_i (!hold_n_sync),
        .clr_i      (clr),
        .count_o    (count),
        .state_o    (state)
    );

    rhd_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .CLR_BIT(CLR_BIT)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .rd_addr_i    (rd_addr_i),
        .count_i      (count),
        .clr_o        (clr),
        .rd_data_o    (rd_data_o),
        .long_press_o (long_press_o)
    );

    // R6: a clear during a press lands in the running state
    p_clr_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hold_n_sync) |=> (state == ST_RUN));
endmodule

// File: tb/reset_hold_counter_tb_top.sv
module reset_hold_counter_tb_top;
    localparam int CW = 10;
    localparam logic [31:0] MAXV = (32'd1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold_n = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        long_press;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    reset_hold_counter #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hold_n_i(hold_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .long_press_o(long_press)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input logic a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic reg_wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic press(input int n);
        @(negedge clk);
        hold_n = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
        hold_n = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset;
        read_chk(1'b0, 32'd0, "R9 count after reset");
        read_chk(1'b1, MAXV, "R9 threshold after reset");
        check("R9 long_press after reset", {31'd0, long_press}, 32'd0);
    endtask

    task automatic t_basic;
        press(37);
        read_chk(1'b0, 32'd37, "R1 R2 count equals held cycles");
        repeat (20) @(posedge clk);
        read_chk(1'b0, 32'd37, "R5 count held after release");
    endtask

    task automatic t_clear;
        reg_wr(1'b0, 32'h7FFF_1234);
        read_chk(1'b0, 32'd37, "R4 write without clear bit ignored");
        reg_wr(1'b0, 32'h8000_0000);
        read_chk(1'b0, 32'd0, "R4 clear bit zeroes count");
    endtask

    task automatic t_repress;
        press(10);
        press(15);
        read_chk(1'b0, 32'd25, "R10 second press accumulates");
        reg_wr(1'b0, 32'h8000_0000);
    endtask

    task automatic t_saturate;
        press(1500);
        read_chk(1'b0, MAXV, "R3 saturates at maximum");
        check("R7 bit31 reads zero", {31'd0, rd_data[31]}, 32'd0);
        check("R9 long_press at max vs default thr", {31'd0, long_press}, 32'd1);
        reg_wr(1'b0, 32'h8000_0000);
    endtask

    task automatic t_clear_low;
        @(negedge clk);
        hold_n = 1'b0;
        repeat (50) @(posedge clk);
        reg_wr(1'b0, 32'h8000_0000);
        repeat (20) @(posedge clk);
        @(negedge clk);
        hold_n = 1'b1;
        repeat (4) @(posedge clk);
        read_chk(1'b0, 32'd22, "R6 restart from zero during press");
        reg_wr(1'b0, 32'h8000_0000);
    endtask

    task automatic t_threshold;
        reg_wr(1'b1, 32'h8000_041E);
        read_chk(1'b1, 32'd30, "R8 threshold masked readback");
        read_chk(1'b0, 32'd0, "R8 threshold write leaves count");
        press(29);
        check("R8 below threshold", {31'd0, long_press}, 32'd0);
        reg_wr(1'b0, 32'h8000_0000);
        press(30);
        check("R8 at threshold", {31'd0, long_press}, 32'd1);
        read_chk(1'b0, 32'd30, "R7 count field");
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_clear();
        t_repress();
        t_saturate();
        t_clear_low();
        t_threshold();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule